// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block gathers thirty-two interrupt request lines into two outgoing interrupt lines: one for urgent (critical) events and one for ordinary (non-critical) events. Each request line can be set up to latch on an edge or to follow a level, and to treat high/rising or low/falling as the active sense. Each line can be enabled on its own and routed to either output. The outputs can feed a parent controller.

Software works through a small synchronous register bus. It reads the latched status and clears it with write-one-to-clear. A masked status view shows only the enabled pending sources. In every register, source n sits at bit (31 - n), so source 0 is the most significant bit. Request inputs may be asynchronous, so each one passes through a two-flop synchronizer first.

Top module: `irq_ctrl32`

## Requirements
- R1: The block has 32 sources. Source n (input `irqIn[n]`) appears at bit (31 - n) of every register, so source 0 is bit 31 and source 31 is bit 0.
- R2: Register word offsets on `busAddr` are: 0 status, 1 enable, 2 critical route, 3 polarity, 4 trigger mode, 5 masked status (read-only). Read data appears on `busRdData` on the clock edge that samples `busRdEn`. Offsets 6 and 7 read as zero.
- R3: Writing status with a 1 in a bit clears that latched bit. A 0 in a bit leaves it unchanged.
- R4: A trigger bit of 1 selects edge mode. With polarity 1 a rising input sets status, and with polarity 0 a falling input sets it. The status bit stays set after the input returns to idle.
- R5: A trigger bit of 0 selects level mode. Status is set while the input is at its active level (high when polarity is 1, low when it is 0). A clear has no effect while the input stays active, even when the source is disabled.
- R6: Status latches whether or not the source is enabled. Enabling a source whose status is already pending asserts its output.
- R7: Masked status reads as status AND enable. A write to offset 5 changes no register. With all enables zero, both outputs stay low.
- R8: An enabled pending source with critical-route bit 1 drives `critIrq`. With bit 0 it drives `normIrq`. Each output is the OR of its own group.
- R9: After reset, status, enable, critical route and trigger are all zero, polarity is all ones (active-high level), and both outputs are low.
- R10: If a clear write and a new edge event hit the same status bit in the same cycle, the bit stays set.
- R11: Latency is fixed. An input change sampled at clock edge k reaches status at edge k+2 and the output at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 3 | Register word offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| irqIn | input | 32 | Interrupt request inputs, index = source number |
| critIrq | output | 1 | Critical interrupt output |
| normIrq | output | 1 | Non-critical interrupt output |

## Verification
On every cycle, the assertions check four things. A status bit only rises when a set event occurred in the previous cycle. A write-one-to-clear removes a bit unless a set event also hit it. An active level-mode source is always latched on the next cycle. With nothing enabled, both outputs stay silent. Only the directed scenarios can show the bit reversal at both ends of the vector and the edge senses in both polarities. They also cover the same-cycle clear-versus-edge race, the exact three-edge output latency, and the routing of a pending source once it is enabled.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_STS  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CRIT = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_POL  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_TRG  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 3'd5;

  typedef struct packed {
    logic              wrSts;
    logic              wrEn;
    logic              wrCrit;
    logic              wrPol;
    logic              wrTrg;
    logic              rdStb;
    logic [ADDR_W-1:0] rdSel;
  } intcStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output intcStrobe_t       strb
);

  always_comb begin
    strb        = '0;
    strb.rdStb  = busRdEn;
    strb.rdSel  = busAddr;
    if (busWrEn) begin
      unique case (busAddr)
        OFS_STS:  strb.wrSts  = 1'b1;
        OFS_EN:   strb.wrEn   = 1'b1;
        OFS_CRIT: strb.wrCrit = 1'b1;
        OFS_POL:  strb.wrPol  = 1'b1;
        OFS_TRG:  strb.wrTrg  = 1'b1;
        default:  ;
      endcase
    end
  end

  // R7
  msk_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_MSK) |->
      !(strb.wrSts || strb.wrEn || strb.wrCrit || strb.wrPol || strb.wrTrg));

  // R2
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSts, strb.wrEn, strb.wrCrit, strb.wrPol, strb.wrTrg}));

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int unsigned NumSrc = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  intcStrobe_t       strb,
  input  logic [NumSrc-1:0] wrData,
  input  logic [NumSrc-1:0] srcBits,
  output logic [NumSrc-1:0] rdData,
  output logic              critIrq,
  output logic              normIrq
);

  logic [NumSrc-1:0] syncA, syncB, prevQ;
  logic [NumSrc-1:0] stsQ, enQ, critQ, polQ, trgQ;
  logic [NumSrc-1:0] actNow, actPrev, edgeHit, levelHit, setEvt, clrMask;
  logic [NumSrc-1:0] mskSts, stsNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= srcBits;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  always_comb begin
    actNow   = ~(syncB ^ polQ);
    actPrev  = ~(prevQ ^ polQ);
    edgeHit  = trgQ & actNow & ~actPrev;
    levelHit = ~trgQ & actNow;
    setEvt   = edgeHit | levelHit;
    clrMask  = strb.wrSts ? wrData : '0;
    stsNext  = setEvt | (stsQ & ~clrMask);
    mskSts   = stsQ & enQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsQ  <= '0;
      enQ   <= '0;
      critQ <= '0;
      polQ  <= '1;
      trgQ  <= '0;
    end else begin
      stsQ <= stsNext;
      if (strb.wrEn)   enQ   <= wrData;
      if (strb.wrCrit) critQ <= wrData;
      if (strb.wrPol)  polQ  <= wrData;
      if (strb.wrTrg)  trgQ  <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      critIrq <= 1'b0;
      normIrq <= 1'b0;
      rdData  <= '0;
    end else begin
      critIrq <= |(mskSts & critQ);
      normIrq <= |(mskSts & ~critQ);
      if (strb.rdStb) begin
        case (strb.rdSel)
          OFS_STS:  rdData <= stsQ;
          OFS_EN:   rdData <= enQ;
          OFS_CRIT: rdData <= critQ;
          OFS_POL:  rdData <= polQ;
          OFS_TRG:  rdData <= trgQ;
          OFS_MSK:  rdData <= mskSts;
          default:  rdData <= '0;
        endcase
      end
    end
  end

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSts |=> ((stsQ & $past(wrData & ~setEvt)) == '0));

  // R5
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stsQ & $past(~trgQ & actNow)) == $past(~trgQ & actNow)));

  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((stsQ & ~$past(stsQ)) & ~$past(setEvt)) == '0));

  // R7
  quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |=> (!critIrq && !normIrq));

  // R7
  msk_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStb && strb.rdSel == OFS_MSK) |=> (rdData == $past(stsQ & enQ)));

endmodule

// File: rtl/irq_ctrl32.sv
module irq_ctrl32
  import intc_pkg::*;
#(
  parameter int unsigned NumSrc = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NumSrc-1:0] busWrData,
  output logic [NumSrc-1:0] busRdData,
  input  logic [NumSrc-1:0] irqIn,
  output logic              critIrq,
  output logic              normIrq
);

  localparam int unsigned TopBit = NumSrc - 1;

  intcStrobe_t       strb;
  logic [NumSrc-1:0] srcBits;

  for (genvar n = 0; n < NumSrc; n++) begin : g_rev
    assign srcBits[TopBit-n] = irqIn[n];
  end

  intc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  intc_datapath #(.NumSrc(NumSrc)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWrData),
    .srcBits (srcBits),
    .rdData  (busRdData),
    .critIrq (critIrq),
    .normIrq (normIrq)
  );

endmodule

// File: tb/irq_ctrl32_tb.sv
module irq_ctrl32_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] irqIn = '0;
  logic        critIrq, normIrq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_ctrl32 u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqIn(irqIn), .critIrq(critIrq), .normIrq(normIrq)
  );

  function automatic logic [31:0] bitOf(int src);
    return 32'h8000_0000 >> src;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    busRead(3'd0, v); check("R9 status", v, 32'h0);
    busRead(3'd1, v); check("R9 enable", v, 32'h0);
    busRead(3'd2, v); check("R9 crit", v, 32'h0);
    busRead(3'd3, v); check("R9 polarity", v, 32'hFFFF_FFFF);
    busRead(3'd4, v); check("R9 trigger", v, 32'h0);
    busRead(3'd5, v); check("R9 masked", v, 32'h0);
    busRead(3'd6, v); check("R2 offset6 zero", v, 32'h0);
    check("R9 outputs", {30'b0, critIrq, normIrq}, 32'h0);
  endtask

  task automatic t_bitOrder();
    logic [31:0] v;
    irqIn[0] = 1'b1; idle(4);
    busRead(3'd0, v); check("R1 source0 is bit31", v, 32'h8000_0000);
    irqIn[0] = 1'b0; irqIn[31] = 1'b1; idle(4);
    busWrite(3'd0, 32'h8000_0000);
    busRead(3'd0, v); check("R1 source31 is bit0", v, 32'h0000_0001);
    irqIn[31] = 1'b0; idle(4);
    busWrite(3'd0, 32'hFFFF_FFFF);
    busRead(3'd0, v); check("R3 cleared all", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    irqIn[3] = 1'b1; idle(4);
    busWrite(3'd0, 32'h0);
    busRead(3'd0, v); check("R3 zero write keeps", v, bitOf(3));
    busWrite(3'd0, bitOf(3)); idle(1);
    busRead(3'd0, v); check("R5 clear while active disabled", v, bitOf(3));
    irqIn[3] = 1'b0; idle(4);
    busRead(3'd0, v); check("R5 latched after drop", v, bitOf(3));
    busWrite(3'd0, bitOf(3));
    busRead(3'd0, v); check("R3 clear after drop", v, 32'h0);
    busWrite(3'd3, ~bitOf(3)); idle(4);
    busRead(3'd0, v); check("R5 active-low level", v, bitOf(3));
    busWrite(3'd3, 32'hFFFF_FFFF); busWrite(3'd0, bitOf(3));
    busRead(3'd0, v); check("R5 active-low restored", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    busWrite(3'd4, bitOf(7));
    irqIn[7] = 1'b1; idle(4); irqIn[7] = 1'b0; idle(4);
    busRead(3'd0, v); check("R4 rising latched", v, bitOf(7));
    busWrite(3'd0, bitOf(7));
    busRead(3'd0, v); check("R4 edge clear", v, 32'h0);
    busWrite(3'd3, ~bitOf(7)); idle(3);
    irqIn[7] = 1'b1; idle(4);
    busRead(3'd0, v); check("R4 no set on rise when falling", v, 32'h0);
    irqIn[7] = 1'b0; idle(4);
    busRead(3'd0, v); check("R4 falling latched", v, bitOf(7));
    busWrite(3'd3, 32'hFFFF_FFFF); busWrite(3'd0, bitOf(7));
  endtask

  task automatic t_race();
    logic [31:0] v;
    irqIn[7] = 1'b1; idle(4); irqIn[7] = 1'b0; idle(4);
    @(negedge clk); irqIn[7] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk);
    busWrite(3'd0, bitOf(7));
    busRead(3'd0, v); check("R10 edge beats clear", v, bitOf(7));
    irqIn[7] = 1'b0; idle(4);
    busWrite(3'd0, bitOf(7));
    busRead(3'd0, v); check("R3 clear after race", v, 32'h0);
    busWrite(3'd4, 32'h0);
  endtask

  task automatic t_route();
    logic [31:0] v;
    irqIn[3] = 1'b1; idle(4);
    check("R6 pending while disabled", {31'b0, normIrq}, 32'h0);
    busWrite(3'd1, bitOf(3)); idle(2);
    check("R6 enable asserts norm", {30'b0, critIrq, normIrq}, 32'h1);
    busRead(3'd5, v); check("R7 masked view", v, bitOf(3));
    busWrite(3'd5, 32'hFFFF_FFFF);
    busRead(3'd1, v); check("R7 offset5 write ignored", v, bitOf(3));
    busWrite(3'd2, bitOf(3)); idle(2);
    check("R8 critical route", {30'b0, critIrq, normIrq}, 32'h2);
    busWrite(3'd2, 32'h0); busWrite(3'd1, 32'h0); idle(2);
    check("R7 disabled outputs low", {30'b0, critIrq, normIrq}, 32'h0);
    irqIn[3] = 1'b0; idle(4);
    busWrite(3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_latency();
    busWrite(3'd1, bitOf(3)); idle(2);
    @(negedge clk); irqIn[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R11 output not yet", {31'b0, normIrq}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R11 output at third edge", {31'b0, normIrq}, 32'h1);
    irqIn[3] = 1'b0; idle(4);
    busWrite(3'd0, bitOf(3)); busWrite(3'd1, 32'h0);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_bitOrder();
    t_level();
    t_edge();
    t_race();
    t_route();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule